// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block carries out the processor state changes that follow the acceptance of a maskable interrupt. It carries an 8-bit vector. When a request arrives while interrupts are enabled, the block captures the vector and the processor state it needs in the acceptance cycle. It then steps through a fixed sequence. First it issues one cycle of write strobes that update the processor state. These updates cover the status word, the user-mode flag, the return address, the exception status, the exception data address and, when the processor was in user mode, the two stack pointers. Next it fetches the handler address from a vector table in memory. Last it loads the program counter with that address.

The status word is pushed into a mode history. The old word is shifted left by a parameterised amount and kept to its low XLEN-2 bits, and the old top bit is kept in place. The vector table entry is read through a simple read port: a one-cycle request with an address, then a wait for a valid or an error response. An error ends the sequence with a one-cycle fault pulse, and the program counter is left alone.

Top module: `irq_entry_seq`

## Requirements
- R1: While `irq_enable` is 0, an asserted `irq_req` is ignored: `busy`, `upd_we`, `rd_req` and `pc_we` stay 0.
- R2: In the cycle right after acceptance, `upd_we` is 1 for exactly one cycle. During that cycle `ccs_out` equals `((old << 10) & 0x3FFF_FFFF) | (old & 0x8000_0000)`, where old is the status word sampled at acceptance.
- R3: `user_clr` is 1 in the same single cycle as `upd_we`, so the user-mode flag is forced off together with the other state writes.
- R4: `stack_we` is 1 in that cycle only if `user_mode` was 1 at acceptance. Then `usp_out` is the accepted `sp_in` and `sp_out` is the accepted `ksp_in`. From kernel mode, `stack_we` stays 0.
- R5: During the update cycle, `erp_out` equals the `pc_in` value sampled at acceptance.
- R6: During the update cycle, `exs_out` equals vector × 256 (vector in bits 15:8, zeros elsewhere) and `eda_out` is 0.
- R7: In the cycle after the update cycle, `rd_req` is 1 for exactly one cycle with `rd_addr` = accepted `ebp_in` + 4 × vector.
- R8: Read data is little-endian, with byte lane k (bits 8k+7:8k) holding the byte at address + k. On `rd_valid`, the next cycle has `pc_we` and `entered` at 1 for one cycle, with `pc_out` equal to the assembled word. The block is idle in the cycle after that.
- R9: On `rd_err` while waiting, the next cycle has `fault` at 1 for one cycle, `busy` at 0 and `pc_we` at 0. An error takes precedence over a valid response in the same cycle.
- R10: `busy` is 1 from the cycle after acceptance until the sequence ends. Changes on any request input while busy have no effect: the update values and the read address stay those captured at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Interrupt request |
| irq_vec | input | 8 | Interrupt vector |
| ccs_in | input | 32 | Current status word |
| user_mode | input | 1 | Processor is in user mode |
| irq_enable | input | 1 | Interrupts enabled |
| sp_in | input | 32 | Current stack pointer |
| ksp_in | input | 32 | Kernel stack pointer |
| pc_in | input | 32 | Current program counter |
| ebp_in | input | 32 | Exception vector table base |
| rd_req | output | 1 | Vector table read request |
| rd_addr | output | 32 | Vector table read address |
| rd_valid | input | 1 | Read data valid |
| rd_err | input | 1 | Read failed |
| rd_data | input | 32 | Read data, byte lane k = address + k |
| busy | output | 1 | Sequence in progress |
| upd_we | output | 1 | Strobe for status, return address, exception status and data address |
| user_clr | output | 1 | Clear the user-mode flag |
| ccs_out | output | 32 | New status word |
| erp_out | output | 32 | New return address |
| exs_out | output | 32 | New exception status |
| eda_out | output | 32 | New exception data address |
| stack_we | output | 1 | Stack pointer swap strobe |
| usp_out | output | 32 | New user stack pointer |
| sp_out | output | 32 | New stack pointer |
| pc_we | output | 1 | Program counter load strobe |
| pc_out | output | 32 | Handler address |
| entered | output | 1 | Sequence completed |
| fault | output | 1 | Vector read failed |

## Verification
The sweep runs every one of the 256 vectors through a full entry. User and kernel origin alternate, so the stack swap is seen both taken and withheld. Each vector gets its own status word, table base and read latency of zero to two wait cycles, which tells the shifted history, the preserved top bit, the vector scaling in the read address and the exception status apart. The table data is built byte by byte, so a swapped lane order shows up. During each sequence the request inputs are driven with unrelated values while the request stays asserted, to show that only the accepted values matter. A run with interrupts disabled, some entries that end in read errors and one response carrying both valid and error at once cover the ignore, abort and precedence cases.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_UPDATE = 3'd1,
    ST_RREQ   = 3'd2,
    ST_RWAIT  = 3'd3,
    ST_DONE   = 3'd4
  } seq_state_e;
endpackage

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept_i,
  input  logic rd_valid_i,
  input  logic rd_err_i,
  output logic busy_o,
  output logic load_o,
  output logic update_o,
  output logic rreq_o,
  output logic hload_o,
  output logic done_o,
  output logic fault_o
);
  seq_state_e state_q, state_d;
  logic       fault_q;
  logic       err_seen;

  assign err_seen = (state_q == ST_RWAIT) && rd_err_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept_i) state_d = ST_UPDATE;
      ST_UPDATE: state_d = ST_RREQ;
      ST_RREQ:   state_d = ST_RWAIT;
      ST_RWAIT:  if (rd_err_i) state_d = ST_IDLE;
                 else if (rd_valid_i) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      fault_q <= err_seen;
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign load_o   = (state_q == ST_IDLE) && accept_i;
  assign update_o = (state_q == ST_UPDATE);
  assign rreq_o   = (state_q == ST_RREQ);
  assign hload_o  = (state_q == ST_RWAIT) && rd_valid_i && !rd_err_i;
  assign done_o   = (state_q == ST_DONE);
  assign fault_o  = fault_q;

  // R7
  rreq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rreq_o |=> !rreq_o);

  // R9
  fault_after_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> ($past(rd_err_i) && !busy_o && !done_o));

  // R2
  update_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update_o |=> (!update_o && rreq_o));
endmodule

// File: rtl/irq_entry_capture.sv
module irq_entry_capture #(
  parameter int XLEN  = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             hload_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [XLEN-1:0]  ccs_i,
  input  logic             user_i,
  input  logic [XLEN-1:0]  sp_i,
  input  logic [XLEN-1:0]  ksp_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  ebp_i,
  input  logic [XLEN-1:0]  handler_i,
  output logic [VEC_W-1:0] vec_o,
  output logic [XLEN-1:0]  ccs_o,
  output logic             user_o,
  output logic [XLEN-1:0]  sp_o,
  output logic [XLEN-1:0]  ksp_o,
  output logic [XLEN-1:0]  pc_o,
  output logic [XLEN-1:0]  ebp_o,
  output logic [XLEN-1:0]  handler_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_o     <= '0;
      ccs_o     <= '0;
      user_o    <= 1'b0;
      sp_o      <= '0;
      ksp_o     <= '0;
      pc_o      <= '0;
      ebp_o     <= '0;
      handler_o <= '0;
    end else begin
      if (load_i) begin
        vec_o  <= vec_i;
        ccs_o  <= ccs_i;
        user_o <= user_i;
        sp_o   <= sp_i;
        ksp_o  <= ksp_i;
        pc_o   <= pc_i;
        ebp_o  <= ebp_i;
      end
      if (hload_i) handler_o <= handler_i;
    end
  end
endmodule

// File: rtl/irq_entry_calc.sv
module irq_entry_calc #(
  parameter int XLEN       = 32,
  parameter int VEC_W      = 8,
  parameter int HIST_SHIFT = 10
) (
  input  logic [XLEN-1:0]  ccs_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [XLEN-1:0]  ebp_i,
  input  logic [XLEN-1:0]  rd_data_i,
  output logic [XLEN-1:0]  ccs_o,
  output logic [XLEN-1:0]  exs_o,
  output logic [XLEN-1:0]  addr_o,
  output logic [XLEN-1:0]  word_o
);
  localparam int NBYTES = XLEN / 8;
  localparam logic [XLEN-1:0] LOW_MASK = {2'b00, {(XLEN-2){1'b1}}};
  localparam logic [XLEN-1:0] TOP_BIT  = {1'b1, {(XLEN-1){1'b0}}};

  function automatic logic [XLEN-1:0] hist_push(input logic [XLEN-1:0] old);
    return ((old << HIST_SHIFT) & LOW_MASK) | (old & TOP_BIT);
  endfunction

  function automatic logic [XLEN-1:0] vec_scaled(input logic [VEC_W-1:0] v, input int sh);
    logic [XLEN-1:0] w;
    w = '0;
    w[VEC_W-1:0] = v;
    return w << sh;
  endfunction

  function automatic logic [XLEN-1:0] le_assemble(input logic [XLEN-1:0] lanes);
    logic [XLEN-1:0] w;
    w = '0;
    for (int k = 0; k < NBYTES; k++) begin
      w = w | ({{(XLEN-8){1'b0}}, lanes[8*k +: 8]} << (8*k));
    end
    return w;
  endfunction

  assign ccs_o  = hist_push(ccs_i);
  assign exs_o  = vec_scaled(vec_i, 8);
  assign addr_o = ebp_i + vec_scaled(vec_i, 2);
  assign word_o = le_assemble(rd_data_i);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int XLEN       = 32,
  parameter int VEC_W      = 8,
  parameter int HIST_SHIFT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_req,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic [XLEN-1:0]  ccs_in,
  input  logic             user_mode,
  input  logic             irq_enable,
  input  logic [XLEN-1:0]  sp_in,
  input  logic [XLEN-1:0]  ksp_in,
  input  logic [XLEN-1:0]  pc_in,
  input  logic [XLEN-1:0]  ebp_in,
  output logic             rd_req,
  output logic [XLEN-1:0]  rd_addr,
  input  logic             rd_valid,
  input  logic             rd_err,
  input  logic [XLEN-1:0]  rd_data,
  output logic             busy,
  output logic             upd_we,
  output logic             user_clr,
  output logic [XLEN-1:0]  ccs_out,
  output logic [XLEN-1:0]  erp_out,
  output logic [XLEN-1:0]  exs_out,
  output logic [XLEN-1:0]  eda_out,
  output logic             stack_we,
  output logic [XLEN-1:0]  usp_out,
  output logic [XLEN-1:0]  sp_out,
  output logic             pc_we,
  output logic [XLEN-1:0]  pc_out,
  output logic             entered,
  output logic             fault
);
  logic             accept_w, load_w, update_w, rreq_w, hload_w, done_w;
  logic [VEC_W-1:0] cap_vec;
  logic [XLEN-1:0]  cap_ccs, cap_sp, cap_ksp, cap_pc, cap_ebp, cap_handler;
  logic             cap_user;
  logic [XLEN-1:0]  calc_word;

  assign accept_w = irq_req && irq_enable;

  irq_entry_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .accept_i(accept_w),
    .rd_valid_i(rd_valid), .rd_err_i(rd_err),
    .busy_o(busy), .load_o(load_w), .update_o(update_w),
    .rreq_o(rreq_w), .hload_o(hload_w), .done_o(done_w), .fault_o(fault)
  );

  irq_entry_capture #(.XLEN(XLEN), .VEC_W(VEC_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .load_i(load_w), .hload_i(hload_w),
    .vec_i(irq_vec), .ccs_i(ccs_in), .user_i(user_mode), .sp_i(sp_in),
    .ksp_i(ksp_in), .pc_i(pc_in), .ebp_i(ebp_in), .handler_i(calc_word),
    .vec_o(cap_vec), .ccs_o(cap_ccs), .user_o(cap_user), .sp_o(cap_sp),
    .ksp_o(cap_ksp), .pc_o(cap_pc), .ebp_o(cap_ebp), .handler_o(cap_handler)
  );

  irq_entry_calc #(.XLEN(XLEN), .VEC_W(VEC_W), .HIST_SHIFT(HIST_SHIFT)) u_calc (
    .ccs_i(cap_ccs), .vec_i(cap_vec), .ebp_i(cap_ebp), .rd_data_i(rd_data),
    .ccs_o(ccs_out), .exs_o(exs_out), .addr_o(rd_addr), .word_o(calc_word)
  );

  assign upd_we   = update_w;
  assign user_clr = update_w;
  assign stack_we = update_w && cap_user;
  assign erp_out  = cap_pc;
  assign eda_out  = '0;
  assign usp_out  = cap_sp;
  assign sp_out   = cap_ksp;
  assign rd_req   = rreq_w;
  assign pc_we    = done_w;
  assign entered  = done_w;
  assign pc_out   = cap_handler;

  // R1
  ignore_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !irq_enable) |=> !busy);

  // R4
  stack_from_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stack_we |-> (upd_we && $past(user_mode && irq_req && irq_enable)));

  // R8
  pc_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> ($past(rd_valid) && !fault));

  // R3
  user_clr_with_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    user_clr |-> $past(!busy && irq_req && irq_enable));
endmodule

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_req = 1'b0;
  logic [7:0]  irq_vec = '0;
  logic [31:0] ccs_in = '0;
  logic        user_mode = 1'b0;
  logic        irq_enable = 1'b0;
  logic [31:0] sp_in = '0, ksp_in = '0, pc_in = '0, ebp_in = '0;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_valid = 1'b0, rd_err = 1'b0;
  logic [31:0] rd_data = '0;
  logic        busy, upd_we, user_clr, stack_we, pc_we, entered, fault;
  logic [31:0] ccs_out, erp_out, exs_out, eda_out, usp_out, sp_out, pc_out;

  int checks = 0;
  int bad = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec),
    .ccs_in(ccs_in), .user_mode(user_mode), .irq_enable(irq_enable),
    .sp_in(sp_in), .ksp_in(ksp_in), .pc_in(pc_in), .ebp_in(ebp_in),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_err(rd_err),
    .rd_data(rd_data), .busy(busy), .upd_we(upd_we), .user_clr(user_clr),
    .ccs_out(ccs_out), .erp_out(erp_out), .exs_out(exs_out), .eda_out(eda_out),
    .stack_we(stack_we), .usp_out(usp_out), .sp_out(sp_out), .pc_we(pc_we),
    .pc_out(pc_out), .entered(entered), .fault(fault)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A ^ {a[3:0], a[7:4]};
  endfunction

  function automatic logic [31:0] exp_hist(input logic [31:0] old);
    logic [31:0] r;
    r = '0;
    for (int b = 0; b < 30; b++) if (b >= 10) r[b] = old[b-10];
    r[31] = old[31];
    return r;
  endfunction

  task automatic run_entry(input int v, input logic usr, input logic [31:0] ccs,
                           input logic [31:0] ebp, input int lat, input logic err,
                           input logic both);
    logic [31:0] sp_a, ksp_a, pc_a, addr_e, word_e;
    sp_a  = 32'h7000_0000 + v * 16;
    ksp_a = 32'h3000_0100 ^ (v << 4);
    pc_a  = 32'h0040_0002 + v * 6;
    addr_e = ebp + v * 4;
    word_e = {mem_byte(addr_e + 3), mem_byte(addr_e + 2), mem_byte(addr_e + 1), mem_byte(addr_e)};
    @(negedge clk);
    irq_req = 1'b1; irq_enable = 1'b1; irq_vec = v[7:0]; ccs_in = ccs;
    user_mode = usr; sp_in = sp_a; ksp_in = ksp_a; pc_in = pc_a; ebp_in = ebp;
    @(negedge clk);
    // update cycle; scramble inputs while request stays high (R10)
    irq_vec = ~v[7:0]; ccs_in = ~ccs; user_mode = ~usr; sp_in = 32'hDEAD_0000;
    ksp_in = 32'hBEEF_0000; pc_in = 32'h1111_1111; ebp_in = 32'h2222_0000;
    chk("R10 busy in update", {31'd0, busy}, 32'd1);
    chk("R2 upd_we", {31'd0, upd_we}, 32'd1);
    chk("R2 ccs_out", ccs_out, exp_hist(ccs));
    chk("R3 user_clr", {31'd0, user_clr}, 32'd1);
    chk("R4 stack_we", {31'd0, stack_we}, {31'd0, usr});
    if (usr) begin
      chk("R4 usp_out", usp_out, sp_a);
      chk("R4 sp_out", sp_out, ksp_a);
    end
    chk("R5 erp_out", erp_out, pc_a);
    chk("R6 exs_out", exs_out, v * 256);
    chk("R6 eda_out", eda_out, 32'd0);
    chk("R7 no early rd_req", {31'd0, rd_req}, 32'd0);
    @(negedge clk);
    chk("R7 rd_req", {31'd0, rd_req}, 32'd1);
    chk("R7 rd_addr", rd_addr, addr_e);
    chk("R2 upd_we single", {31'd0, upd_we}, 32'd0);
    @(negedge clk);
    irq_req = 1'b0;
    chk("R7 rd_req single", {31'd0, rd_req}, 32'd0);
    for (int i = 0; i < lat; i++) begin
      chk("R10 busy while waiting", {31'd0, busy}, 32'd1);
      chk("R8 no pc_we while waiting", {31'd0, pc_we}, 32'd0);
      @(negedge clk);
    end
    rd_data = {mem_byte(rd_addr + 3), mem_byte(rd_addr + 2), mem_byte(rd_addr + 1), mem_byte(rd_addr)};
    rd_valid = !err || both;
    rd_err = err;
    @(negedge clk);
    rd_valid = 1'b0; rd_err = 1'b0; rd_data = 32'hFFFF_FFFF;
    if (err) begin
      chk("R9 fault", {31'd0, fault}, 32'd1);
      chk("R9 not busy", {31'd0, busy}, 32'd0);
      chk("R9 no pc_we", {31'd0, pc_we}, 32'd0);
      chk("R9 no entered", {31'd0, entered}, 32'd0);
      @(negedge clk);
      chk("R9 fault single", {31'd0, fault}, 32'd0);
      chk("R9 stays idle", {31'd0, pc_we}, 32'd0);
    end else begin
      chk("R8 pc_we", {31'd0, pc_we}, 32'd1);
      chk("R8 entered", {31'd0, entered}, 32'd1);
      chk("R8 pc_out", pc_out, word_e);
      chk("R8 no fault", {31'd0, fault}, 32'd0);
      @(negedge clk);
      chk("R8 idle after", {31'd0, busy}, 32'd0);
      chk("R8 pc_we single", {31'd0, pc_we}, 32'd0);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset busy", {31'd0, busy}, 32'd0);
    chk("R7 reset rd_req", {31'd0, rd_req}, 32'd0);
    chk("R8 reset pc_we", {31'd0, pc_we}, 32'd0);
    chk("R9 reset fault", {31'd0, fault}, 32'd0);
    chk("R2 reset upd_we", {31'd0, upd_we}, 32'd0);
    // R1: request with interrupts disabled
    irq_req = 1'b1; irq_enable = 1'b0; irq_vec = 8'h33;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R1 busy", {31'd0, busy}, 32'd0);
      chk("R1 upd_we", {31'd0, upd_we}, 32'd0);
      chk("R1 rd_req", {31'd0, rd_req}, 32'd0);
      chk("R1 pc_we", {31'd0, pc_we}, 32'd0);
    end
    irq_req = 1'b0;
    for (int v = 0; v < 256; v++) begin
      logic [31:0] c;
      c = (v * 32'h0101_0101) ^ ((v % 2 == 1) ? 32'h8000_0001 : 32'h4000_0000) ^ (v << 22);
      run_entry(v, v[0], c, 32'h1000_0000 + (v << 9) + ((v % 4) * 4), v % 3,
                (v % 17) == 5, 1'b0);
    end
    // R9: valid and error together, error wins
    run_entry(200, 1'b1, 32'hFFFF_FFFF, 32'h0000_0FF0, 1, 1'b1, 1'b1);
    run_entry(255, 1'b0, 32'h8000_0000, 32'hFFFF_FC00, 0, 1'b0, 1'b0);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule